// File: doc/BRIEF.md
# Jitter Monitor Sample Accumulator

This block estimates clock jitter in real time for a random number generator that samples a jittered clock with a second, related clock. Within one pattern period there are KD samples, and each one lands at a different phase offset of the jittered waveform. The block places every sample into the slot that matches its phase, not its arrival position. It keeps one counter per slot and adds the sample bits over Q whole pattern periods. The slot counters then form an image of the sampled waveform.

When a window closes, the block walks through the slots one per cycle. It counts the slots whose totals are mixed, meaning neither zero nor equal to Q. These slots lie in the rising or falling transition region of the waveform, so their number grows with the jitter. The count is published with a one-cycle valid pulse and is held until the next result. The counters are then cleared, and the next window opens at the next period-start strobe.

The phase step KM, the slot count KD and the window length Q are static configuration inputs. They are changed only while no window is running. The block needs KD of at least 2 and Q of at least 1.

Top module: `jitter_slot_monitor`

## Requirements
- R1: After reset, resultValid is low and jitterCount is zero.
- R2: A window opens on the first sample that has sampleValid and periodStart both high. That sample counts as sample 0 of period 0. Valid samples that arrive before it are not accumulated.
- R3: Sample j of a period (j from 0 to KD-1) is added to slot (j*KM) mod KD. KM may be larger than KD.
- R4: sampleBit is accumulated only in cycles where sampleValid is high. Cycles with sampleValid low do not advance the sample position.
- R5: A window holds exactly Q*KD valid samples. The scan of the slots starts after the last of them.
- R6: A slot is critical when its total is greater than 0 and less than Q. Slots with a total of 0 or of Q are not critical, so a window with Q equal to 1 always reports zero.
- R7: The reported jitterCount is the number of critical slots among slots 0 to KD-1, so it never exceeds KD.
- R8: resultValid is high for exactly one cycle per window. jitterCount changes only in the cycle where resultValid rises, and it keeps its value until the next result.
- R9: Windows repeat. All slot totals restart from zero after each result. Samples that arrive during the scan, or while no window is open and periodStart is low, are dropped.
- R10: A periodStart strobe that arrives while a window is accumulating has no effect on the slot sequence or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | High when sampleBit carries a sample |
| sampleBit | input | 1 | Sampled level of the jittered clock |
| periodStart | input | 1 | Marks sample 0 of a pattern period |
| cfgKm | input | KM_W | Phase step KM between successive samples |
| cfgKd | input | clog2(MAX_KD+1) | Number of slots KD, from 2 to MAX_KD |
| cfgQ | input | clog2(MAX_Q+1) | Number of periods Q per window, at least 1 |
| jitterCount | output | clog2(MAX_KD+1) | Number of critical slots from the last window |
| resultValid | output | 1 | One-cycle pulse when a new jitterCount is available |

## Verification
The main function is driven with several synthetic waveforms: a clean square wave, constant ones, constant zeros, and edges with mixed regions of chosen widths (1+1, 3+3 and 4+2 slots). The clean and constant cases show that totals of 0 or Q are never counted. The mixed-edge cases check that the count equals the width of the transition region under both step/slot settings (212/207 and 516/175). A single one in a whole window, and a slot that misses exactly one period, probe both sides of the critical test. Further cases check that idle gaps, stray samples before a window opens, samples during the scan, a window with Q of 1, and periodStart strobes in every period leave the count unchanged.

// File: rtl/jm_pkg.sv
package jm_pkg;

  typedef enum logic [1:0] {
    JM_IDLE  = 2'd0,
    JM_ACCUM = 2'd1,
    JM_SCAN  = 2'd2
  } jm_state_e;

  typedef struct packed {
    logic accumEn;   // add sampleBit into current slot and advance slot index
    logic scanEn;    // evaluate one slot during the scan
    logic scanLast;  // final slot of the scan: publish and clear
  } jm_strobe_t;

endpackage

// File: rtl/jm_ctrl.sv
module jm_ctrl
  import jm_pkg::*;
#(
  parameter int KD_W  = 9,
  parameter int ACC_W = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic             periodStart,
  input  logic [KD_W-1:0]  cfgKd,
  input  logic [ACC_W-1:0] cfgQ,
  output jm_strobe_t       strobe
);

  jm_state_e        state;
  logic [KD_W-1:0]  sampleCnt;
  logic [ACC_W-1:0] periodCnt;
  logic [KD_W-1:0]  kdLast;
  logic [ACC_W-1:0] qLast;
  logic             lastInPeriod;

  assign kdLast       = cfgKd - KD_W'(1);
  assign qLast        = cfgQ - ACC_W'(1);
  assign lastInPeriod = (sampleCnt == kdLast);

  always_comb begin
    strobe          = '0;
    strobe.accumEn  = sampleValid &&
                      (((state == JM_IDLE) && periodStart) || (state == JM_ACCUM));
    strobe.scanEn   = (state == JM_SCAN);
    strobe.scanLast = (state == JM_SCAN) && lastInPeriod;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= JM_IDLE;
      sampleCnt <= '0;
      periodCnt <= '0;
    end else begin
      unique case (state)
        JM_IDLE: begin
          if (strobe.accumEn) begin
            state     <= JM_ACCUM;
            sampleCnt <= KD_W'(1);
            periodCnt <= '0;
          end
        end
        JM_ACCUM: begin
          if (strobe.accumEn) begin
            if (lastInPeriod) begin
              sampleCnt <= '0;
              if (periodCnt == qLast) begin
                state     <= JM_SCAN;
                periodCnt <= '0;
              end else begin
                periodCnt <= periodCnt + ACC_W'(1);
              end
            end else begin
              sampleCnt <= sampleCnt + KD_W'(1);
            end
          end
        end
        JM_SCAN: begin
          if (strobe.scanLast) begin
            state     <= JM_IDLE;
            sampleCnt <= '0;
          end else begin
            sampleCnt <= sampleCnt + KD_W'(1);
          end
        end
        default: state <= JM_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/jm_datapath.sv
module jm_datapath
  import jm_pkg::*;
#(
  parameter int MAX_KD = 256,
  parameter int KM_W   = 10,
  parameter int KD_W   = 9,
  parameter int SLOT_W = 8,
  parameter int ACC_W  = 10,
  parameter int CNT_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  jm_strobe_t        strobe,
  input  logic              sampleBit,
  input  logic [KM_W-1:0]   cfgKm,
  input  logic [KD_W-1:0]   cfgKd,
  input  logic [ACC_W-1:0]  cfgQ,
  output logic [SLOT_W-1:0] slotIdx,
  output logic [CNT_W-1:0]  jitterCount,
  output logic              resultValid
);

  // Phase step reduced modulo KD by a restoring remainder chain
  logic [KD_W:0]   remChain;
  logic [KD_W-1:0] kmMod;

  always_comb begin
    remChain = '0;
    for (int b = KM_W - 1; b >= 0; b--) begin
      remChain = {remChain[KD_W-1:0], cfgKm[b]};
      if (remChain >= {1'b0, cfgKd}) remChain = remChain - {1'b0, cfgKd};
    end
    kmMod = remChain[KD_W-1:0];
  end

  // Modular adder for the next slot
  logic [KD_W:0] sumIdx;
  logic [KD_W:0] wrapIdx;

  assign sumIdx  = {{(KD_W + 1 - SLOT_W){1'b0}}, slotIdx} + {1'b0, kmMod};
  assign wrapIdx = (sumIdx >= {1'b0, cfgKd}) ? (sumIdx - {1'b0, cfgKd}) : sumIdx;

  // Per-slot accumulator bank
  logic [ACC_W-1:0] accBank [MAX_KD];

  for (genvar g = 0; g < MAX_KD; g++) begin : g_slot
    logic [ACC_W-1:0] slotAcc;
    logic             slotHit;

    assign slotHit    = strobe.accumEn && (slotIdx == SLOT_W'(g));
    assign accBank[g] = slotAcc;

    always_ff @(posedge clk) begin
      if (!rstN || strobe.scanLast) slotAcc <= '0;
      else if (slotHit)             slotAcc <= slotAcc + ACC_W'(sampleBit);
    end
  end

  // Sequential scan for critical slots
  logic [SLOT_W-1:0] scanPtr;
  logic [CNT_W-1:0]  runCount;
  logic [ACC_W-1:0]  curTotal;
  logic              isCritical;

  assign curTotal   = accBank[scanPtr];
  assign isCritical = (curTotal != '0) && (curTotal < cfgQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotIdx     <= '0;
      scanPtr     <= '0;
      runCount    <= '0;
      jitterCount <= '0;
      resultValid <= 1'b0;
    end else begin
      resultValid <= 1'b0;
      if (strobe.accumEn) slotIdx <= wrapIdx[SLOT_W-1:0];
      if (strobe.scanEn) begin
        if (strobe.scanLast) begin
          jitterCount <= runCount + CNT_W'(isCritical);
          resultValid <= 1'b1;
          runCount    <= '0;
          scanPtr     <= '0;
          slotIdx     <= '0;
        end else begin
          runCount <= runCount + CNT_W'(isCritical);
          scanPtr  <= scanPtr + SLOT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/jitter_slot_monitor.sv
module jitter_slot_monitor
  import jm_pkg::*;
#(
  parameter  int MAX_KD = 256,
  parameter  int KM_W   = 10,
  parameter  int MAX_Q  = 1023,
  localparam int KD_W   = $clog2(MAX_KD + 1),
  localparam int SLOT_W = $clog2(MAX_KD),
  localparam int ACC_W  = $clog2(MAX_Q + 1),
  localparam int CNT_W  = $clog2(MAX_KD + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic             sampleBit,
  input  logic             periodStart,
  input  logic [KM_W-1:0]  cfgKm,
  input  logic [KD_W-1:0]  cfgKd,
  input  logic [ACC_W-1:0] cfgQ,
  output logic [CNT_W-1:0] jitterCount,
  output logic             resultValid
);

  jm_strobe_t        strobe;
  logic [SLOT_W-1:0] slotIdx;

  jm_ctrl #(
    .KD_W (KD_W),
    .ACC_W(ACC_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .periodStart(periodStart),
    .cfgKd      (cfgKd),
    .cfgQ       (cfgQ),
    .strobe     (strobe)
  );

  jm_datapath #(
    .MAX_KD(MAX_KD),
    .KM_W  (KM_W),
    .KD_W  (KD_W),
    .SLOT_W(SLOT_W),
    .ACC_W (ACC_W),
    .CNT_W (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sampleBit  (sampleBit),
    .cfgKm      (cfgKm),
    .cfgKd      (cfgKd),
    .cfgQ       (cfgQ),
    .slotIdx    (slotIdx),
    .jitterCount(jitterCount),
    .resultValid(resultValid)
  );

endmodule

// File: rtl/jm_checker.sv
module jm_checker #(
  parameter int KD_W   = 9,
  parameter int SLOT_W = 8,
  parameter int CNT_W  = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic [KD_W-1:0]   cfgKd,
  input logic [SLOT_W-1:0] slotIdx,
  input logic [CNT_W-1:0]  jitterCount,
  input logic              resultValid
);

  // R8
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);

  // R8
  hold_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(jitterCount));

  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> (KD_W'(jitterCount) <= cfgKd));

  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    KD_W'(slotIdx) < cfgKd);

endmodule

bind jitter_slot_monitor jm_checker #(
  .KD_W  (KD_W),
  .SLOT_W(SLOT_W),
  .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgKd      (cfgKd),
  .slotIdx    (slotIdx),
  .jitterCount(jitterCount),
  .resultValid(resultValid)
);

// File: tb/tb_jitter_slot_monitor.sv
module tb_jitter_slot_monitor;

  localparam int MAX_KD = 256;
  localparam int KM_W   = 10;
  localparam int MAX_Q  = 1023;
  localparam int KD_W   = $clog2(MAX_KD + 1);
  localparam int ACC_W  = $clog2(MAX_Q + 1);
  localparam int CNT_W  = $clog2(MAX_KD + 1);

  logic             clk = 1'b0;
  logic             rstN;
  logic             sampleValid;
  logic             sampleBit;
  logic             periodStart;
  logic [KM_W-1:0]  cfgKm;
  logic [KD_W-1:0]  cfgKd;
  logic [ACC_W-1:0] cfgQ;
  logic [CNT_W-1:0] jitterCount;
  logic             resultValid;

  always #4 clk = ~clk;  // 125 MHz

  jitter_slot_monitor #(.MAX_KD(MAX_KD), .KM_W(KM_W), .MAX_Q(MAX_Q)) dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleBit(sampleBit),
    .periodStart(periodStart), .cfgKm(cfgKm), .cfgKd(cfgKd), .cfgQ(cfgQ),
    .jitterCount(jitterCount), .resultValid(resultValid)
  );

  int    checks = 0;
  int    errors = 0;
  bit    finished = 0;
  int    expQ[$];
  string tagQ[$];
  int    lastExp = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Waveform model indexed by phase slot
  function automatic bit bitFor(input int mode, input int slot, input int p,
                                input int kd, input int wr, input int wf);
    int half;
    half = kd / 2;
    case (mode)
      0: return slot < half;
      1: begin
        if (slot < 20)           return 1'b0;
        if (slot < 20 + wr)      return 1'((slot + p) % 2);
        if (slot < half)         return 1'b1;
        if (slot < half + wf)    return 1'((slot + p) % 2);
        return 1'b0;
      end
      2: return 1'b1;
      3: return 1'b0;
      4: return (slot == 5) && (p == 0);
      5: return (slot == 7) ? (p != 0) : (slot == 9);
      default: return 1'b0;
    endcase
  endfunction

  task automatic driveIdle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sampleValid = 1'b0; sampleBit = 1'b0; periodStart = 1'b0;
    end
  endtask

  // Driver: computes the expected result and pushes it, then drives the window
  task automatic runWindow(input int km, input int kd, input int q, input int mode,
                           input int wr, input int wf, input bit strayFirst,
                           input bit everyPeriodStart, input string tag);
    int tot[MAX_KD];
    int crit;
    for (int s = 0; s < MAX_KD; s++) tot[s] = 0;
    for (int p = 0; p < q; p++)
      for (int j = 0; j < kd; j++) begin
        int slot;
        slot = (j * km) % kd;
        tot[slot] += int'(bitFor(mode, slot, p, kd, wr, wf));
      end
    crit = 0;
    for (int s = 0; s < kd; s++) if (tot[s] > 0 && tot[s] < q) crit++;
    expQ.push_back(crit);
    tagQ.push_back(tag);

    @(negedge clk);
    cfgKm = KM_W'(km); cfgKd = KD_W'(kd); cfgQ = ACC_W'(q);
    sampleValid = 1'b0; periodStart = 1'b0;
    // R2: stray valid samples before the window opens
    if (strayFirst)
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        sampleValid = 1'b1; sampleBit = 1'b1; periodStart = 1'b0;
      end
    for (int p = 0; p < q; p++)
      for (int j = 0; j < kd; j++) begin
        int slot;
        slot = (j * km) % kd;
        // R4: idle cycle carrying a one that must be ignored
        if (j % 37 == 3) begin
          @(negedge clk);
          sampleValid = 1'b0; sampleBit = 1'b1; periodStart = 1'b1;
        end
        @(negedge clk);
        sampleValid = 1'b1;
        sampleBit   = bitFor(mode, slot, p, kd, wr, wf);
        periodStart = (j == 0) && (p == 0 || everyPeriodStart);  // R10
      end
    // R9: samples during the scan and afterwards without periodStart
    for (int i = 0; i < kd + 4; i++) begin
      @(negedge clk);
      sampleValid = 1'b1; sampleBit = 1'b1; periodStart = 1'b0;
    end
    driveIdle(3);
  endtask

  // Monitor: pops expected results as the design produces them
  initial begin
    forever begin
      @(negedge clk);
      if (rstN === 1'b1 && resultValid === 1'b1) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R8 unexpected result", int'(jitterCount), -1);
        end else begin
          int    e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          lastExp = e;
          check(int'(jitterCount) == e, t, int'(jitterCount), e);
        end
        @(negedge clk);
        check(resultValid == 1'b0, "R8 pulse width", int'(resultValid), 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; sampleValid = 1'b0; sampleBit = 1'b0; periodStart = 1'b0;
    cfgKm = KM_W'(212); cfgKd = KD_W'(207); cfgQ = ACC_W'(4);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(resultValid == 1'b0, "R1 valid after reset", int'(resultValid), 0);
    check(jitterCount == '0, "R1 count after reset", int'(jitterCount), 0);

    runWindow(212, 207, 4, 1, 1, 1, 1'b1, 1'b0, "R2/R4/R6 edge 1+1");
    runWindow(516, 175, 5, 1, 3, 3, 1'b0, 1'b0, "R3/R7 edge 3+3");
    runWindow(212, 207, 3, 0, 0, 0, 1'b0, 1'b0, "R6 clean square");
    runWindow(516, 175, 2, 2, 0, 0, 1'b0, 1'b0, "R6 all ones");
    runWindow(516, 175, 2, 3, 0, 0, 1'b0, 1'b0, "R6 all zeros");
    runWindow(212, 207, 4, 4, 0, 0, 1'b0, 1'b0, "R6 single one");
    runWindow(212, 207, 4, 5, 0, 0, 1'b0, 1'b0, "R6 total Q-1");
    runWindow(212, 207, 6, 1, 4, 2, 1'b0, 1'b1, "R10 periodStart each period");
    runWindow(23, 10, 1, 1, 2, 2, 1'b0, 1'b0, "R5/R6 Q of one");
    runWindow(516, 175, 3, 1, 2, 1, 1'b1, 1'b0, "R9 back-to-back window");

    driveIdle(20);
    check(int'(jitterCount) == lastExp, "R8 count held", int'(jitterCount), lastExp);
    check(expQ.size() == 0, "R5/R9 all results produced", expQ.size(), 0);

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule